// File: doc/BRIEF.md
# Multi-Field Program Counter Sequencer

This block keeps the complete program-counter state of one hardware thread. It holds five fields: the current instruction address, the address to execute after it, the address after that (which carries the branch-delay-slot shadow), a micro-operation index and the index of the next micro-operation. The decode, prediction and memory stages around it tell it what kind of instruction is retiring from the front end. It then moves the one dimension of the state that such an instruction moves: the micro index for a micro-operation inside a longer macro-operation, or the macro address fields for a full instruction or the final micro-operation.

A redirect port loads the state from a single target address. An advance strobe carries the instruction length and a set of flags for micro-operation, last micro-operation, control transfer, predicted taken, conditional delay slot and return. The `DELAY_SLOT` parameter selects between two variants. One is an architecture with branch delay slots and a fixed 4-byte instruction word, where a taken branch lets the delay slot run and a predicted-not-taken conditional branch annuls it. The other has no delay slots and uses the supplied variable instruction length. A return that is not predicted taken parks the sequencer: the fetch address is withheld until a redirect delivers the resolved target.

Top module: `pcs_sequencer`

## Requirements
- R1: After reset the current address is `RESET_ADDR` (0), the next address is 4, the next-next address is 8, the micro index is 0, the next micro index is 1, and fetch is valid.
- R2: A redirect to address A gives, one cycle later, current A, next A+4, next-next A+8, micro index 0, next micro index 1, and fetch valid with fetch address A.
- R3: An advance flagged as a micro-operation that is not the last one copies the next micro index into the micro index and increments the next micro index. All three macro address fields stay unchanged, whatever the control flags say.
- R4: With delay slots, a sequential advance of a full instruction or of a last micro-operation shifts current←next and next←next-next, sets next-next to the old next-next + 4, and resets the micro indices to 0 and 1. The length input has no effect in this variant.
- R5: Without delay slots, a sequential advance with length L sets current to the old current + L, next to that + 4 and next-next to that + 8.
- R6: With delay slots, an advance with control=1 and predicted-taken=1 moves current to the old next address (the delay slot), next to the target and next-next to target + 4. A taken return follows this same path.
- R7: With delay slots, an advance with control=1, conditional-delay-slot=1 and predicted-taken=0 skips the delay slot: current becomes the old current + 8, next the old current + 12, and next-next the old current + 16. Without delay slots the same flags act as a sequential advance.
- R8: Without delay slots, an advance with control=1 and predicted-taken=1 loads current with the target, next with target + 4 and next-next with target + 8.
- R9: An advance with control=1, return=1 and predicted-taken=0 clears the valid flag. While the flag is clear, the fetch address output reads 0, fetch-valid reads 0, and advances leave every field unchanged.
- R10: A redirect takes priority over an advance in the same cycle, and it sets the valid flag again after a park.
- R11: Predicted-taken, return and conditional-delay-slot have no effect while control=0. With the advance strobe low, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| redirect_i | input | 1 | Load the state from redirect_addr_i |
| redirect_addr_i | input | AW | Redirect target address |
| adv_i | input | 1 | Advance strobe for one retiring instruction or micro-operation |
| adv_len_i | input | LW | Byte length of the advancing instruction (used without delay slots) |
| uop_i | input | 1 | Advancing item is a micro-operation |
| uop_last_i | input | 1 | Micro-operation is the last of its macro-operation |
| ctrl_i | input | 1 | Advancing item is a control transfer |
| pred_taken_i | input | 1 | Control transfer predicted taken |
| cond_ds_i | input | 1 | Conditional branch whose delay slot is annulled when not taken |
| ret_i | input | 1 | Control transfer is a return |
| target_i | input | AW | Predicted branch target |
| fetch_addr_o | output | AW | Current address while valid, else 0 |
| fetch_valid_o | output | 1 | Valid flag |
| upc_o | output | UW | Current micro index |
| nupc_o | output | UW | Next micro index |
| npc_o | output | AW | Predicted next address |
| nnpc_o | output | AW | Predicted next-next address |

## Verification
Two events can coincide in one cycle: a redirect and an advance. The most telling case pairs a redirect with a taken-branch advance that carries a different target, issued while the sequencer is parked after an unpredicted return. The result is correct only if the state holds the redirect address with its derived fields and the valid flag is set again, with no trace of the branch target. A second overlap, an advance that arrives while parked, is driven in the cycle before the redirect and must leave every visible field unchanged.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Kind of state movement selected for one cycle
  typedef enum logic [2:0] {
    ADV_NONE  = 3'd0,  // nothing moves
    ADV_MICRO = 3'd1,  // micro index only
    ADV_SEQ   = 3'd2,  // sequential macro step
    ADV_JUMP  = 3'd3,  // predicted-taken control transfer
    ADV_SKIP  = 3'd4,  // annulled delay slot
    ADV_PARK  = 3'd5   // unpredicted return, wait for redirect
  } adv_kind_e;

endpackage

// File: rtl/pcs_classify.sv
module pcs_classify
  import pcs_pkg::*;
#(
  parameter int DELAY_SLOT = 1
) (
  input  logic      valid_i,
  input  logic      adv_i,
  input  logic      uop_i,
  input  logic      uop_last_i,
  input  logic      ctrl_i,
  input  logic      pred_taken_i,
  input  logic      cond_ds_i,
  input  logic      ret_i,
  output adv_kind_e kind_o
);

  localparam logic SKIP_EN = (DELAY_SLOT != 0);

  logic micro_frag;
  assign micro_frag = uop_i && !uop_last_i;

  always_comb begin
    kind_o = ADV_NONE;
    if (valid_i && adv_i) begin
      if (micro_frag)                          kind_o = ADV_MICRO;
      else if (ctrl_i && pred_taken_i)         kind_o = ADV_JUMP;
      else if (ctrl_i && ret_i)                kind_o = ADV_PARK;
      else if (ctrl_i && cond_ds_i && SKIP_EN) kind_o = ADV_SKIP;
      else                                     kind_o = ADV_SEQ;
    end
  end

endmodule

// File: rtl/pcs_macro_next.sv
module pcs_macro_next
  import pcs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 4,
  parameter int ISZ        = 4,
  parameter int DELAY_SLOT = 1
) (
  input  adv_kind_e        kind_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    npc_i,
  input  logic [AW-1:0]    nnpc_i,
  input  logic [AW-1:0]    target_i,
  input  logic [LW-1:0]    len_i,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    npc_o,
  output logic [AW-1:0]    nnpc_o
);

  localparam logic [AW-1:0] STEP1 = AW'(ISZ);
  localparam logic [AW-1:0] STEP2 = AW'(2 * ISZ);

  generate
    if (DELAY_SLOT != 0) begin : g_delay
      logic unused_len;
      assign unused_len = ^len_i;

      always_comb begin
        pc_o   = pc_i;
        npc_o  = npc_i;
        nnpc_o = nnpc_i;
        unique case (kind_i)
          ADV_SEQ: begin
            pc_o   = npc_i;
            npc_o  = nnpc_i;
            nnpc_o = nnpc_i + STEP1;
          end
          ADV_JUMP: begin
            pc_o   = npc_i;
            npc_o  = target_i;
            nnpc_o = target_i + STEP1;
          end
          ADV_SKIP: begin
            pc_o   = nnpc_i;
            npc_o  = nnpc_i + STEP1;
            nnpc_o = nnpc_i + STEP2;
          end
          default: ;
        endcase
      end
    end else begin : g_flat
      logic [AW-1:0] fall;
      assign fall = pc_i + {{(AW-LW){1'b0}}, len_i};

      always_comb begin
        pc_o   = pc_i;
        npc_o  = npc_i;
        nnpc_o = nnpc_i;
        unique case (kind_i)
          ADV_SEQ: begin
            pc_o   = fall;
            npc_o  = fall + STEP1;
            nnpc_o = fall + STEP2;
          end
          ADV_JUMP: begin
            pc_o   = target_i;
            npc_o  = target_i + STEP1;
            nnpc_o = target_i + STEP2;
          end
          default: ;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/pcs_micro_next.sv
module pcs_micro_next
  import pcs_pkg::*;
#(
  parameter int UW = 8
) (
  input  adv_kind_e     kind_i,
  input  logic [UW-1:0] upc_i,
  input  logic [UW-1:0] nupc_i,
  output logic [UW-1:0] upc_o,
  output logic [UW-1:0] nupc_o
);

  localparam logic [UW-1:0] ONE = UW'(1);

  always_comb begin
    upc_o  = upc_i;
    nupc_o = nupc_i;
    unique case (kind_i)
      ADV_MICRO: begin
        upc_o  = nupc_i;
        nupc_o = nupc_i + ONE;
      end
      ADV_SEQ, ADV_JUMP, ADV_SKIP: begin
        upc_o  = '0;
        nupc_o = ONE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pcs_sequencer.sv
module pcs_sequencer
  import pcs_pkg::*;
#(
  parameter int              AW         = 32,
  parameter int              LW         = 4,
  parameter int              UW         = 8,
  parameter int              ISZ        = 4,
  parameter int              DELAY_SLOT = 1,
  parameter logic [AW-1:0]   RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_addr_i,
  input  logic          adv_i,
  input  logic [LW-1:0] adv_len_i,
  input  logic          uop_i,
  input  logic          uop_last_i,
  input  logic          ctrl_i,
  input  logic          pred_taken_i,
  input  logic          cond_ds_i,
  input  logic          ret_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic          fetch_valid_o,
  output logic [UW-1:0] upc_o,
  output logic [UW-1:0] nupc_o,
  output logic [AW-1:0] npc_o,
  output logic [AW-1:0] nnpc_o
);

  localparam logic [AW-1:0] STEP1 = AW'(ISZ);
  localparam logic [AW-1:0] STEP2 = AW'(2 * ISZ);
  localparam logic [UW-1:0] UONE  = UW'(1);

  // reset release synchronizer
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // state
  logic [AW-1:0] pc_q, npc_q, nnpc_q;
  logic [UW-1:0] upc_q, nupc_q;
  logic          valid_q;

  // next-state candidates
  adv_kind_e     kind;
  logic [AW-1:0] pc_adv, npc_adv, nnpc_adv;
  logic [UW-1:0] upc_adv, nupc_adv;
  logic [AW-1:0] pc_d, npc_d, nnpc_d;
  logic [UW-1:0] upc_d, nupc_d;
  logic          valid_d;
  logic          upd_en;

  pcs_classify #(.DELAY_SLOT(DELAY_SLOT)) u_classify (
    .valid_i      (valid_q),
    .adv_i        (adv_i),
    .uop_i        (uop_i),
    .uop_last_i   (uop_last_i),
    .ctrl_i       (ctrl_i),
    .pred_taken_i (pred_taken_i),
    .cond_ds_i    (cond_ds_i),
    .ret_i        (ret_i),
    .kind_o       (kind)
  );

  pcs_macro_next #(
    .AW(AW), .LW(LW), .ISZ(ISZ), .DELAY_SLOT(DELAY_SLOT)
  ) u_macro (
    .kind_i   (kind),
    .pc_i     (pc_q),
    .npc_i    (npc_q),
    .nnpc_i   (nnpc_q),
    .target_i (target_i),
    .len_i    (adv_len_i),
    .pc_o     (pc_adv),
    .npc_o    (npc_adv),
    .nnpc_o   (nnpc_adv)
  );

  pcs_micro_next #(.UW(UW)) u_micro (
    .kind_i (kind),
    .upc_i  (upc_q),
    .nupc_i (nupc_q),
    .upc_o  (upc_adv),
    .nupc_o (nupc_adv)
  );

  // next-state selection: redirect wins over any advance
  always_comb begin
    if (redirect_i) begin
      pc_d    = redirect_addr_i;
      npc_d   = redirect_addr_i + STEP1;
      nnpc_d  = redirect_addr_i + STEP2;
      upc_d   = '0;
      nupc_d  = UONE;
      valid_d = 1'b1;
    end else begin
      pc_d    = pc_adv;
      npc_d   = npc_adv;
      nnpc_d  = nnpc_adv;
      upc_d   = upc_adv;
      nupc_d  = nupc_adv;
      valid_d = valid_q && (kind != ADV_PARK);
    end
  end

  assign upd_en = redirect_i || (kind != ADV_NONE);

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q    <= RESET_ADDR;
      npc_q   <= RESET_ADDR + STEP1;
      nnpc_q  <= RESET_ADDR + STEP2;
      upc_q   <= '0;
      nupc_q  <= UONE;
      valid_q <= 1'b1;
    end else if (upd_en) begin
      pc_q    <= pc_d;
      npc_q   <= npc_d;
      nnpc_q  <= nnpc_d;
      upc_q   <= upc_d;
      nupc_q  <= nupc_d;
      valid_q <= valid_d;
    end
  end

  assign fetch_addr_o  = valid_q ? pc_q : '0;
  assign fetch_valid_o = valid_q;
  assign upc_o         = upc_q;
  assign nupc_o        = nupc_q;
  assign npc_o         = npc_q;
  assign nnpc_o        = nnpc_q;

endmodule

// File: rtl/pcs_sequencer_chk.sv
module pcs_sequencer_chk #(
  parameter int AW         = 32,
  parameter int LW         = 4,
  parameter int UW         = 8,
  parameter int ISZ        = 4,
  parameter int DELAY_SLOT = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          redirect_i,
  input logic [AW-1:0] redirect_addr_i,
  input logic          adv_i,
  input logic          uop_i,
  input logic          uop_last_i,
  input logic          ctrl_i,
  input logic          pred_taken_i,
  input logic          ret_i,
  input logic [AW-1:0] target_i,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] npc_q,
  input logic [AW-1:0] nnpc_q,
  input logic [UW-1:0] upc_q,
  input logic [UW-1:0] nupc_q,
  input logic          valid_q,
  input logic [AW-1:0] fetch_addr_o
);

  localparam logic [AW-1:0] STEP1 = AW'(ISZ);
  localparam logic [UW-1:0] UONE  = UW'(1);

  logic full_step;
  assign full_step = !redirect_i && valid_q && adv_i && !(uop_i && !uop_last_i);

  // R2: redirect loads the whole state from one address
  a_r2_redirect_load: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> valid_q && pc_q == $past(redirect_addr_i) &&
                   npc_q == pc_q + STEP1 && nnpc_q == npc_q + STEP1 &&
                   upc_q == '0 && nupc_q == UONE);

  // R3: micro step leaves macro fields alone
  a_r3_micro_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_i && valid_q && adv_i && uop_i && !uop_last_i) |=>
      $stable(pc_q) && $stable(npc_q) && $stable(nnpc_q) &&
      upc_q == $past(nupc_q) && nupc_q == $past(nupc_q) + UONE);

  // R6 / R8: a taken transfer delivers its target to the right field
  a_r6_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
    (full_step && ctrl_i && pred_taken_i) |=>
      ((DELAY_SLOT != 0) ? npc_q : pc_q) == $past(target_i));

  // R9: unpredicted return parks the sequencer
  a_r9_park: assert property (@(posedge clk) disable iff (!rst_n)
    (full_step && ctrl_i && ret_i && !pred_taken_i) |=> !valid_q);

  // R9: parked state holds until redirect
  a_r9_parked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_i && !valid_q) |=>
      !valid_q && $stable(pc_q) && $stable(npc_q) && $stable(upc_q));

  // R9: no fetch address leaks while parked
  a_r9_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> fetch_addr_o == '0);

endmodule

bind pcs_sequencer pcs_sequencer_chk #(
  .AW(AW), .LW(LW), .UW(UW), .ISZ(ISZ), .DELAY_SLOT(DELAY_SLOT)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .redirect_i      (redirect_i),
  .redirect_addr_i (redirect_addr_i),
  .adv_i           (adv_i),
  .uop_i           (uop_i),
  .uop_last_i      (uop_last_i),
  .ctrl_i          (ctrl_i),
  .pred_taken_i    (pred_taken_i),
  .ret_i           (ret_i),
  .target_i        (target_i),
  .pc_q            (pc_q),
  .npc_q           (npc_q),
  .nnpc_q          (nnpc_q),
  .upc_q           (upc_q),
  .nupc_q          (nupc_q),
  .valid_q         (valid_q),
  .fetch_addr_o    (fetch_addr_o)
);

// File: tb/test_pcs_sequencer.sv
module test_pcs_sequencer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        redirect, adv, uop, lst, ctl, tkn, cds, ret;
  logic [31:0] raddr, tgt;
  logic [3:0]  len;

  logic [31:0] d_fa, d_npc, d_nnpc, n_fa, n_npc, n_nnpc;
  logic [7:0]  d_upc, d_nupc, n_upc, n_nupc;
  logic        d_v, n_v;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pcs_sequencer i_pcs_sequencer (
    .clk(clk), .rst_n(rst_n), .redirect_i(redirect), .redirect_addr_i(raddr),
    .adv_i(adv), .adv_len_i(len), .uop_i(uop), .uop_last_i(lst), .ctrl_i(ctl),
    .pred_taken_i(tkn), .cond_ds_i(cds), .ret_i(ret), .target_i(tgt),
    .fetch_addr_o(d_fa), .fetch_valid_o(d_v), .upc_o(d_upc), .nupc_o(d_nupc),
    .npc_o(d_npc), .nnpc_o(d_nnpc));

  pcs_sequencer #(.DELAY_SLOT(0)) i_pcs_sequencer_nd (
    .clk(clk), .rst_n(rst_n), .redirect_i(redirect), .redirect_addr_i(raddr),
    .adv_i(adv), .adv_len_i(len), .uop_i(uop), .uop_last_i(lst), .ctrl_i(ctl),
    .pred_taken_i(tkn), .cond_ds_i(cds), .ret_i(ret), .target_i(tgt),
    .fetch_addr_o(n_fa), .fetch_valid_o(n_v), .upc_o(n_upc), .nupc_o(n_nupc),
    .npc_o(n_npc), .nnpc_o(n_nnpc));

  // flags order: {uop, last, ctrl, taken, cond_ds, ret}
  typedef struct packed {
    logic [7:0]  req;
    logic        rd;
    logic [31:0] ra;
    logic        adv;
    logic [3:0]  len;
    logic [5:0]  fl;
    logic [31:0] tgt;
    logic [31:0] epc, enpc, ennpc;
    logic [7:0]  eup, enup;
    logic        ev;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R2 redirect
    '{8'd2, 1'b1, 32'h100, 1'b0, 4'd0, 6'b000000, 32'h0, 32'h100, 32'h104, 32'h108, 8'd0, 8'd1, 1'b1},
    // R4 sequential
    '{8'd4, 1'b0, 32'h0, 1'b1, 4'd0, 6'b000000, 32'h0, 32'h104, 32'h108, 32'h10C, 8'd0, 8'd1, 1'b1},
    // R3 micro steps
    '{8'd3, 1'b0, 32'h0, 1'b1, 4'd0, 6'b100000, 32'h0, 32'h104, 32'h108, 32'h10C, 8'd1, 8'd2, 1'b1},
    '{8'd3, 1'b0, 32'h0, 1'b1, 4'd0, 6'b101100, 32'h880, 32'h104, 32'h108, 32'h10C, 8'd2, 8'd3, 1'b1},
    // R4 last micro-op
    '{8'd4, 1'b0, 32'h0, 1'b1, 4'd0, 6'b110000, 32'h0, 32'h108, 32'h10C, 32'h110, 8'd0, 8'd1, 1'b1},
    // R6 taken branch, delay slot kept
    '{8'd6, 1'b0, 32'h0, 1'b1, 4'd0, 6'b001100, 32'h200, 32'h10C, 32'h200, 32'h204, 8'd0, 8'd1, 1'b1},
    // R4 delay slot then target
    '{8'd4, 1'b0, 32'h0, 1'b1, 4'd0, 6'b000000, 32'h0, 32'h200, 32'h204, 32'h208, 8'd0, 8'd1, 1'b1},
    // R7 annulled delay slot
    '{8'd7, 1'b0, 32'h0, 1'b1, 4'd0, 6'b001010, 32'h0, 32'h208, 32'h20C, 32'h210, 8'd0, 8'd1, 1'b1},
    // R11 strobe low
    '{8'd11, 1'b0, 32'h0, 1'b0, 4'd0, 6'b001111, 32'h999, 32'h208, 32'h20C, 32'h210, 8'd0, 8'd1, 1'b1},
    // R9 park
    '{8'd9, 1'b0, 32'h0, 1'b1, 4'd0, 6'b001001, 32'h0, 32'h0, 32'h20C, 32'h210, 8'd0, 8'd1, 1'b0},
    // R9 advance while parked ignored
    '{8'd9, 1'b0, 32'h0, 1'b1, 4'd0, 6'b100000, 32'h0, 32'h0, 32'h20C, 32'h210, 8'd0, 8'd1, 1'b0},
    // R10 redirect beats taken branch, clears park
    '{8'd10, 1'b1, 32'h300, 1'b1, 4'd0, 6'b001100, 32'h400, 32'h300, 32'h304, 32'h308, 8'd0, 8'd1, 1'b1},
    // R11 flags without ctrl
    '{8'd11, 1'b0, 32'h0, 1'b1, 4'd0, 6'b000111, 32'h777, 32'h304, 32'h308, 32'h30C, 8'd0, 8'd1, 1'b1},
    // R6 taken return
    '{8'd6, 1'b0, 32'h0, 1'b1, 4'd0, 6'b001101, 32'h500, 32'h308, 32'h500, 32'h504, 8'd0, 8'd1, 1'b1},
    // R4 length ignored with delay slots
    '{8'd4, 1'b0, 32'h0, 1'b1, 4'd2, 6'b000000, 32'h0, 32'h500, 32'h504, 32'h508, 8'd0, 8'd1, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic r, input logic [31:0] ra, input logic a, input logic [3:0] l,
                       input logic [5:0] f, input logic [31:0] t);
    @(negedge clk);
    redirect = r; raddr = ra; adv = a; len = l; tgt = t;
    {uop, lst, ctl, tkn, cds, ret} = f;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_nd(input string req, input logic [31:0] fa, input logic [31:0] np,
                        input logic [31:0] nnp, input logic v);
    chk(req, "nd fetch", n_fa, fa);
    chk(req, "nd npc", n_npc, np);
    chk(req, "nd nnpc", n_nnpc, nnp);
    chk(req, "nd valid", {31'd0, n_v}, {31'd0, v});
  endtask

  initial begin
    redirect = 1'b0; raddr = '0; adv = 1'b0; len = '0; tgt = '0;
    {uop, lst, ctl, tkn, cds, ret} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state, both variants
    chk("R1", "fetch", d_fa, 32'h0);
    chk("R1", "npc", d_npc, 32'h4);
    chk("R1", "nnpc", d_nnpc, 32'h8);
    chk("R1", "upc", {24'd0, d_upc}, 32'd0);
    chk("R1", "nupc", {24'd0, d_nupc}, 32'd1);
    chk("R1", "valid", {31'd0, d_v}, 32'd1);
    chk_nd("R1", 32'h0, 32'h4, 32'h8, 1'b1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      drive(VECS[i].rd, VECS[i].ra, VECS[i].adv, VECS[i].len, VECS[i].fl, VECS[i].tgt);
      chk(tag, "fetch", d_fa, VECS[i].ev ? VECS[i].epc : 32'h0);
      chk(tag, "npc", d_npc, VECS[i].enpc);
      chk(tag, "nnpc", d_nnpc, VECS[i].ennpc);
      chk(tag, "upc", {24'd0, d_upc}, {24'd0, VECS[i].eup});
      chk(tag, "nupc", {24'd0, d_nupc}, {24'd0, VECS[i].enup});
      chk(tag, "valid", {31'd0, d_v}, {31'd0, VECS[i].ev});
    end

    // no-delay-slot variant, directed
    drive(1'b1, 32'h1000, 1'b0, 4'd0, 6'b000000, 32'h0);
    chk_nd("R2", 32'h1000, 32'h1004, 32'h1008, 1'b1);
    drive(1'b0, 32'h0, 1'b1, 4'd3, 6'b000000, 32'h0);
    chk_nd("R5", 32'h1003, 32'h1007, 32'h100B, 1'b1);
    drive(1'b0, 32'h0, 1'b1, 4'd6, 6'b000000, 32'h0);
    chk_nd("R5", 32'h1009, 32'h100D, 32'h1011, 1'b1);
    drive(1'b0, 32'h0, 1'b1, 4'd2, 6'b001100, 32'h2000);
    chk_nd("R8", 32'h2000, 32'h2004, 32'h2008, 1'b1);
    drive(1'b0, 32'h0, 1'b1, 4'd4, 6'b001010, 32'h0);
    chk_nd("R7", 32'h2004, 32'h2008, 32'h200C, 1'b1);
    drive(1'b0, 32'h0, 1'b1, 4'd4, 6'b001001, 32'h0);
    chk_nd("R9", 32'h0, 32'h2008, 32'h200C, 1'b0);
    drive(1'b0, 32'h0, 1'b1, 4'd4, 6'b000000, 32'h0);
    chk_nd("R9", 32'h0, 32'h2008, 32'h200C, 1'b0);
    drive(1'b1, 32'h3000, 1'b1, 4'd4, 6'b000000, 32'h0);
    chk_nd("R10", 32'h3000, 32'h3004, 32'h3008, 1'b1);

    drive(1'b0, 32'h0, 1'b0, 4'd0, 6'b000000, 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule